// File: doc/BRIEF.md
# Class-Quota Multi-Issue Selector

This block sits beside an eight-entry instruction window in a small superscalar front end and decides, every cycle, which entries go to the execution resources. An entry can be chosen only when no older entry that is still in the window conflicts with it through a register. Issue is not capped by one total width. Each class has its own quota: two memory-access slots, one floating-point slot and one integer slot. An entry with no conflicts is passed over once its class quota is used up, even when slots of other classes are idle.

The selector works from the window contents alone and keeps no state besides its output registers. In each cycle it computes a hazard bit for every entry and runs one priority picker per class. The winners are latched into four slot outputs, and an issue mask tells the window which entries to retire. Entry 0 is the oldest entry. The window presents its contents on flat buses. Entry i uses bits `[2i+1:2i]` of the class bus, and bits `[5i+4:5i]` of each register bus. The class codes are 00 memory access, 01 floating point, 10 integer, and 11 reserved.

Top module: `issue_selector`

## Requirements
- R1: While `rst` is high at a rising edge, every slot valid bit, every slot index and the whole issue mask are cleared to zero.
- R2: An entry is eligible only if its valid bit is set and no valid entry with a lower index has a hazard with it. A hazard is: the older entry's destination equals either source of the entry (RAW), the older destination equals its destination (WAW), or either older source equals its destination (WAR). Invalid older entries never cause a hazard.
- R3: At most two entries of class 00 are chosen. Slot LS0 gets the lowest-indexed eligible one and slot LS1 the next. LS1 is valid only if LS0 is valid, and its index is then higher.
- R4: At most one entry of class 01 is chosen, and it is the lowest-indexed eligible one of that class.
- R5: At most one entry of class 10 is chosen, and it is the lowest-indexed eligible one of that class.
- R6: An eligible entry whose class quota is already taken by older entries is not chosen, even when slots of other classes are unused.
- R7: A younger eligible entry issues while an older conflicting entry stays held. An older entry that is itself chosen in the same cycle still blocks younger entries that conflict with it.
- R8: Entries of class 11 are never chosen, but while valid they still block younger entries that conflict with them.
- R9: Bit i of `issued_o` is set exactly when some valid slot carries index i. A slot whose valid bit is low shows index 0.
- R10: All outputs are registered. They reflect the window as sampled at the previous rising edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| win_valid_i | input | 8 | Per-entry occupancy, bit 0 = oldest |
| win_class_i | input | 16 | Two-bit class code per entry |
| win_dst_i | input | 40 | Five-bit destination register per entry |
| win_src0_i | input | 40 | Five-bit first source register per entry |
| win_src1_i | input | 40 | Five-bit second source register per entry |
| ls0_vld_o | output | 1 | First memory-access slot holds a choice |
| ls0_idx_o | output | 3 | Window index in first memory-access slot |
| ls1_vld_o | output | 1 | Second memory-access slot holds a choice |
| ls1_idx_o | output | 3 | Window index in second memory-access slot |
| fp_vld_o | output | 1 | Floating-point slot holds a choice |
| fp_idx_o | output | 3 | Window index in floating-point slot |
| fx_vld_o | output | 1 | Integer slot holds a choice |
| fx_idx_o | output | 3 | Window index in integer slot |
| issued_o | output | 8 | Mask of entries chosen this cycle |

## Verification
The bench puts two eligible floating-point entries side by side. A selector that counted only the total width would issue both, or move one of them into an idle slot. It also builds each hazard kind on its own, so a selector that missed the WAR or WAW comparison would issue the younger entry early. Older entries that are chosen in the same cycle, invalid older entries and reserved-class entries each get a directed case. Each of these cases separates a design that ignores hazards from one that blocks too much, and catches a reserved entry that leaks out on a slot. A mid-cycle input change checks that the outputs stay latched. Seeded random windows with a narrow register range mix all of these cases and are compared against a sequential reference model.

// File: rtl/issue_sel_pkg.sv
package issue_sel_pkg;

  typedef enum logic [1:0] {
    CLS_MEM = 2'b00,
    CLS_FLT = 2'b01,
    CLS_INT = 2'b10,
    CLS_RSV = 2'b11
  } iclass_e;

endpackage

// File: rtl/issue_hazard_matrix.sv
module issue_hazard_matrix #(
  parameter int N     = 8,
  parameter int REG_W = 5
) (
  input  logic [N-1:0]       valid_i,
  input  logic [N*REG_W-1:0] dst_i,
  input  logic [N*REG_W-1:0] src0_i,
  input  logic [N*REG_W-1:0] src1_i,
  output logic [N-1:0]       blocked_o
);

  // Each entry is compared against every older valid entry. Whether an
  // older entry is chosen this cycle does not matter, so there is no
  // serial chain between entries.
  for (genvar j = 0; j < N; j++) begin : g_young
    logic [REG_W-1:0] my_dst, my_s0, my_s1;
    assign my_dst = dst_i[j*REG_W +: REG_W];
    assign my_s0  = src0_i[j*REG_W +: REG_W];
    assign my_s1  = src1_i[j*REG_W +: REG_W];

    always_comb begin
      logic hit;
      hit = 1'b0;
      for (int i = 0; i < j; i++) begin
        if (valid_i[i]) begin
          if (dst_i[i*REG_W +: REG_W] == my_s0 ||
              dst_i[i*REG_W +: REG_W] == my_s1)  hit = 1'b1; // read after write
          if (dst_i[i*REG_W +: REG_W] == my_dst) hit = 1'b1; // write after write
          if (src0_i[i*REG_W +: REG_W] == my_dst ||
              src1_i[i*REG_W +: REG_W] == my_dst) hit = 1'b1; // write after read
        end
      end
      blocked_o[j] = hit;
    end
  end

endmodule

// File: rtl/issue_class_picker.sv
module issue_class_picker
  import issue_sel_pkg::*;
#(
  parameter int      N     = 8,
  parameter int      IW    = 3,
  parameter int      SLOTS = 1,
  parameter iclass_e CLS   = CLS_MEM
) (
  input  logic [N-1:0]        elig_i,
  input  logic [2*N-1:0]      cls_i,
  output logic [SLOTS-1:0]    vld_o,
  output logic [SLOTS*IW-1:0] idx_o,
  output logic [N-1:0]        take_o
);

  // Slot s takes the lowest-indexed candidate left after slots 0..s-1.
  always_comb begin
    logic [N-1:0] rem;
    logic         hit;
    for (int i = 0; i < N; i++)
      rem[i] = elig_i[i] && (cls_i[2*i +: 2] == CLS);
    vld_o  = '0;
    idx_o  = '0;
    take_o = '0;
    for (int s = 0; s < SLOTS; s++) begin
      hit = 1'b0;
      for (int i = 0; i < N; i++) begin
        if (!hit && rem[i]) begin
          hit                  = 1'b1;
          vld_o[s]             = 1'b1;
          idx_o[s*IW +: IW]    = IW'(i);
          rem[i]               = 1'b0;
          take_o[i]            = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/issue_selector.sv
module issue_selector
  import issue_sel_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_REGS    = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int REG_W      = $clog2(NUM_REGS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_ENTRIES-1:0]       win_valid_i,
  input  logic [2*NUM_ENTRIES-1:0]     win_class_i,
  input  logic [NUM_ENTRIES*REG_W-1:0] win_dst_i,
  input  logic [NUM_ENTRIES*REG_W-1:0] win_src0_i,
  input  logic [NUM_ENTRIES*REG_W-1:0] win_src1_i,
  output logic                         ls0_vld_o,
  output logic [IDX_W-1:0]             ls0_idx_o,
  output logic                         ls1_vld_o,
  output logic [IDX_W-1:0]             ls1_idx_o,
  output logic                         fp_vld_o,
  output logic [IDX_W-1:0]             fp_idx_o,
  output logic                         fx_vld_o,
  output logic [IDX_W-1:0]             fx_idx_o,
  output logic [NUM_ENTRIES-1:0]       issued_o
);

  localparam int LS_QUOTA = 2;
  localparam int FP_QUOTA = 1;
  localparam int FX_QUOTA = 1;

  logic [NUM_ENTRIES-1:0]    blocked, elig;
  logic [LS_QUOTA-1:0]       ls_vld;
  logic [LS_QUOTA*IDX_W-1:0] ls_idx;
  logic [FP_QUOTA-1:0]       fp_vld;
  logic [FP_QUOTA*IDX_W-1:0] fp_idx;
  logic [FX_QUOTA-1:0]       fx_vld;
  logic [FX_QUOTA*IDX_W-1:0] fx_idx;
  logic [NUM_ENTRIES-1:0]    ls_take, fp_take, fx_take;

  issue_hazard_matrix #(.N(NUM_ENTRIES), .REG_W(REG_W)) u_hazard (
    .valid_i  (win_valid_i),
    .dst_i    (win_dst_i),
    .src0_i   (win_src0_i),
    .src1_i   (win_src1_i),
    .blocked_o(blocked)
  );

  assign elig = win_valid_i & ~blocked;

  issue_class_picker #(.N(NUM_ENTRIES), .IW(IDX_W), .SLOTS(LS_QUOTA), .CLS(CLS_MEM)) u_pick_ls (
    .elig_i(elig), .cls_i(win_class_i), .vld_o(ls_vld), .idx_o(ls_idx), .take_o(ls_take)
  );

  issue_class_picker #(.N(NUM_ENTRIES), .IW(IDX_W), .SLOTS(FP_QUOTA), .CLS(CLS_FLT)) u_pick_fp (
    .elig_i(elig), .cls_i(win_class_i), .vld_o(fp_vld), .idx_o(fp_idx), .take_o(fp_take)
  );

  issue_class_picker #(.N(NUM_ENTRIES), .IW(IDX_W), .SLOTS(FX_QUOTA), .CLS(CLS_INT)) u_pick_fx (
    .elig_i(elig), .cls_i(win_class_i), .vld_o(fx_vld), .idx_o(fx_idx), .take_o(fx_take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ls0_vld_o <= 1'b0;
      ls0_idx_o <= '0;
      ls1_vld_o <= 1'b0;
      ls1_idx_o <= '0;
      fp_vld_o  <= 1'b0;
      fp_idx_o  <= '0;
      fx_vld_o  <= 1'b0;
      fx_idx_o  <= '0;
      issued_o  <= '0;
    end else begin
      ls0_vld_o <= ls_vld[0];
      ls0_idx_o <= ls_idx[0 +: IDX_W];
      ls1_vld_o <= ls_vld[1];
      ls1_idx_o <= ls_idx[IDX_W +: IDX_W];
      fp_vld_o  <= fp_vld[0];
      fp_idx_o  <= fp_idx;
      fx_vld_o  <= fx_vld[0];
      fx_idx_o  <= fx_idx;
      issued_o  <= ls_take | fp_take | fx_take;
    end
  end

  function automatic logic [1:0] cls_at(logic [2*NUM_ENTRIES-1:0] v, logic [IDX_W-1:0] k);
    return v[{k, 1'b0} +: 2];
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (issued_o == '0 && !ls0_vld_o && !ls1_vld_o && !fp_vld_o && !fx_vld_o)); // R1
  AST_ISSUED_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (issued_o & ~$past(win_valid_i)) == '0); // R2
  AST_LS_ORDER: assert property (@(posedge clk) disable iff (rst)
    ls1_vld_o |-> (ls0_vld_o && ls1_idx_o > ls0_idx_o)); // R3
  AST_LS0_CLASS: assert property (@(posedge clk) disable iff (rst)
    ls0_vld_o |-> cls_at($past(win_class_i), ls0_idx_o) == CLS_MEM); // R3
  AST_FP_CLASS: assert property (@(posedge clk) disable iff (rst)
    fp_vld_o |-> cls_at($past(win_class_i), fp_idx_o) == CLS_FLT); // R4
  AST_FX_CLASS: assert property (@(posedge clk) disable iff (rst)
    fx_vld_o |-> cls_at($past(win_class_i), fx_idx_o) == CLS_INT); // R5
  AST_ISSUE_COUNT: assert property (@(posedge clk) disable iff (rst)
    $countones(issued_o) == 32'(ls0_vld_o) + 32'(ls1_vld_o) + 32'(fp_vld_o) + 32'(fx_vld_o)); // R9
  AST_IDLE_FP_IDX: assert property (@(posedge clk) disable iff (rst)
    !fp_vld_o |-> fp_idx_o == '0); // R9

endmodule

// File: tb/issue_selector_tb_top.sv
`timescale 1ns/1ps
module issue_selector_tb_top;

  localparam int N  = 8;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    win_valid;
  logic [2*N-1:0]  win_class;
  logic [N*RW-1:0] win_dst, win_src0, win_src1;
  logic ls0_v, ls1_v, fp_v, fx_v;
  logic [2:0] ls0_i, ls1_i, fp_i, fx_i;
  logic [N-1:0] issued;

  always #10 clk = ~clk;

  issue_selector dut_i (
    .clk(clk), .rst(rst),
    .win_valid_i(win_valid), .win_class_i(win_class),
    .win_dst_i(win_dst), .win_src0_i(win_src0), .win_src1_i(win_src1),
    .ls0_vld_o(ls0_v), .ls0_idx_o(ls0_i), .ls1_vld_o(ls1_v), .ls1_idx_o(ls1_i),
    .fp_vld_o(fp_v), .fp_idx_o(fp_i), .fx_vld_o(fx_v), .fx_idx_o(fx_i),
    .issued_o(issued)
  );

  int tests = 0;
  int fails = 0;

  bit       v [N];
  bit [1:0] c [N];
  bit [4:0] d [N], s0 [N], s1 [N];

  bit e_ls0v, e_ls1v, e_fpv, e_fxv;
  bit [2:0] e_ls0i, e_ls1i, e_fpi, e_fxi;
  bit [N-1:0] e_iss;

  task automatic pack_inputs();
    for (int i = 0; i < N; i++) begin
      win_valid[i]            = v[i];
      win_class[2*i +: 2]     = c[i];
      win_dst[i*RW +: RW]     = d[i];
      win_src0[i*RW +: RW]    = s0[i];
      win_src1[i*RW +: RW]    = s1[i];
    end
  endtask

  task automatic clear_win();
    for (int i = 0; i < N; i++) begin
      v[i] = 0; c[i] = 2'b00;
      d[i] = 5'(i); s0[i] = 5'(8 + i); s1[i] = 5'(16 + i);
    end
  endtask

  // Sequential reference model built from the requirements.
  task automatic ref_model();
    bit elig [N];
    int nls;
    for (int j = 0; j < N; j++) begin
      bit dep = 0;
      for (int i = 0; i < j; i++)
        if (v[i] && (d[i] == s0[j] || d[i] == s1[j] || d[i] == d[j] ||
                     s0[i] == d[j] || s1[i] == d[j])) dep = 1;
      elig[j] = v[j] && !dep;
    end
    e_ls0v = 0; e_ls1v = 0; e_fpv = 0; e_fxv = 0;
    e_ls0i = 0; e_ls1i = 0; e_fpi = 0; e_fxi = 0; e_iss = '0;
    nls = 0;
    for (int j = 0; j < N; j++) begin
      if (elig[j]) begin
        if (c[j] == 2'b00 && nls == 0) begin e_ls0v = 1; e_ls0i = 3'(j); e_iss[j] = 1; nls = 1; end
        else if (c[j] == 2'b00 && nls == 1) begin e_ls1v = 1; e_ls1i = 3'(j); e_iss[j] = 1; nls = 2; end
        else if (c[j] == 2'b01 && !e_fpv) begin e_fpv = 1; e_fpi = 3'(j); e_iss[j] = 1; end
        else if (c[j] == 2'b10 && !e_fxv) begin e_fxv = 1; e_fxi = 3'(j); e_iss[j] = 1; end
      end
    end
  endtask

  task automatic check_out(string tag);
    tests++;
    if ({ls0_v, ls0_i, ls1_v, ls1_i, fp_v, fp_i, fx_v, fx_i, issued} !==
        {e_ls0v, e_ls0i, e_ls1v, e_ls1i, e_fpv, e_fpi, e_fxv, e_fxi, e_iss}) begin
      fails++;
      $display("FAIL %s: got ls0=%0b/%0d ls1=%0b/%0d fp=%0b/%0d fx=%0b/%0d iss=%b exp ls0=%0b/%0d ls1=%0b/%0d fp=%0b/%0d fx=%0b/%0d iss=%b",
               tag, ls0_v, ls0_i, ls1_v, ls1_i, fp_v, fp_i, fx_v, fx_i, issued,
               e_ls0v, e_ls0i, e_ls1v, e_ls1i, e_fpv, e_fpi, e_fxv, e_fxi, e_iss);
    end
  endtask

  // Drive at a falling edge, let one rising edge latch, sample at the next falling edge.
  task automatic run_vec(string tag);
    @(negedge clk);
    pack_inputs();
    ref_model();
    @(posedge clk);
    @(negedge clk);
    check_out(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got no finish exp finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    clear_win();
    for (int i = 0; i < N; i++) v[i] = 1;
    pack_inputs();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    e_ls0v = 0; e_ls1v = 0; e_fpv = 0; e_fxv = 0;
    e_ls0i = 0; e_ls1i = 0; e_fpi = 0; e_fxi = 0; e_iss = '0;
    check_out("R1 reset state");
    rst = 1'b0;

    // Empty window: no slot valid, indices zero.
    clear_win();
    run_vec("R9 empty window");

    // Eight independent memory ops: only the two oldest.
    clear_win();
    for (int i = 0; i < N; i++) v[i] = 1;
    run_vec("R3 memory quota");

    // Two independent FP ops and one integer: the second FP is skipped.
    clear_win();
    v[0] = 1; c[0] = 2'b01; v[1] = 1; c[1] = 2'b01; v[2] = 1; c[2] = 2'b10;
    run_vec("R6 R4 fp quota");

    // Older FP reads an integer result; younger FP goes around it.
    clear_win();
    v[0] = 1; c[0] = 2'b10; d[0] = 5'd30;
    v[1] = 1; c[1] = 2'b01; s0[1] = 5'd30;
    v[2] = 1; c[2] = 2'b01;
    run_vec("R7 out of order");

    // Write after read hazard.
    clear_win();
    v[0] = 1; s1[0] = 5'd29; v[1] = 1; d[1] = 5'd29; v[2] = 1;
    run_vec("R2 war");

    // Write after write: two integer ops share a destination.
    clear_win();
    v[0] = 1; c[0] = 2'b10; d[0] = 5'd3;
    v[1] = 1; c[1] = 2'b10; d[1] = 5'd3;
    v[2] = 1; c[2] = 2'b01; d[2] = 5'd3;
    run_vec("R2 R5 waw");

    // Reserved class blocks but never issues.
    clear_win();
    v[0] = 1; c[0] = 2'b11; d[0] = 5'd28;
    v[1] = 1; c[1] = 2'b00; s0[1] = 5'd28;
    v[2] = 1; c[2] = 2'b10;
    run_vec("R8 reserved class");

    // Invalid older entry does not block.
    clear_win();
    d[0] = 5'd27; v[1] = 1; s0[1] = 5'd27;
    run_vec("R2 invalid older");

    // Chosen older entry still blocks a dependent younger one.
    clear_win();
    v[0] = 1; c[0] = 2'b00; d[0] = 5'd26;
    v[1] = 1; c[1] = 2'b01; s1[1] = 5'd26;
    run_vec("R7 same cycle block");

    // Outputs hold between edges.
    clear_win();
    for (int i = 0; i < N; i++) v[i] = 1;
    run_vec("R10 setup");
    clear_win();
    pack_inputs();
    #3;
    check_out("R10 hold between edges");
    @(posedge clk);
    @(negedge clk);
    ref_model();
    check_out("R10 next edge");

    // Seeded random windows with a narrow register range.
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < N; i++) begin
        v[i]  = ($urandom % 5) != 0;
        c[i]  = 2'($urandom % 4);
        d[i]  = 5'($urandom % 12);
        s0[i] = 5'($urandom % 12);
        s1[i] = 5'($urandom % 12);
      end
      run_vec("random R2 R3 R4 R5 R6 R7 R8");
    end

    // Reset mid-run with a busy window.
    @(negedge clk);
    clear_win();
    for (int i = 0; i < N; i++) v[i] = 1;
    pack_inputs();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    e_ls0v = 0; e_ls1v = 0; e_fpv = 0; e_fxv = 0;
    e_ls0i = 0; e_ls1i = 0; e_fpi = 0; e_fxi = 0; e_iss = '0;
    check_out("R1 mid-run reset");
    rst = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule